// File: doc/BRIEF.md
# Reset, Mode Capture and Interrupt Pin Conditioner

This block sits between the package pins and a processor core. It turns an asynchronous, active-low reset into a clean reset for the core and clears a small clock-phase counter while reset is held. On release it samples three mode pins once and keeps them as the core's starting operating mode. After that, one of those pins is reused as an active-low interrupt request. The request can be masked and can be set to follow the pin level or to latch falling edges.

Every raw input passes through a two-stage synchronizer, so the delay from reset release to the first active phase is a fixed number of clocks. Instances whose reset is released on the same clock edge therefore start in lock-step. The controller state machine has three states. `ST_HOLD` is reset held. `ST_CAPTURE` is the single cycle after the mode has been latched. `ST_RUN` is normal operation. Its transitions are HOLD→CAPTURE once the synchronized reset is seen high (the mode is taken on this edge), CAPTURE→RUN unconditionally, and any state→HOLD asynchronously when reset is asserted.

Edge detection has its own state machine. `IQ_OFF` means not running or in level mode. `IQ_ARMED` waits for a falling edge. `IQ_LATCHED` means an edge is pending. Its transitions are OFF→ARMED when running in edge mode, OFF/ARMED→LATCHED on a falling edge, LATCHED→ARMED on acknowledge without a new edge, and any→OFF when leaving run or edge mode. The core reports whether it sits in wait or stop, and the block raises a wake signal for each case.

Top module: `pinctl_top`

## Requirements
- R1: `core_rst_n` goes low at once while `rst_n_raw` is low. After `rst_n_raw` rises, `core_rst_n` is still low after the 3rd rising clock edge and is high after the 4th.
- R2: `phase_o` is 0 whenever `core_rst_n` is low and in the first cycle of run. It then advances by one per clock and wraps from PHASES-1 (default 4 phases) to 0.
- R3: `mode_o` bit k equals the level of `mode_pins_n[k]` held across reset release. Pins stable across the release give one of 8 values.
- R4: Pin activity while running never changes `mode_o`.
- R5: In level mode (`irq_edge_sel`=0), `irq_pend_o` is 1 while the synchronized `mode_pins_n[0]` is low, 2 clocks after the pin changes.
- R6: In edge mode (`irq_edge_sel`=1), a high-to-low transition of `mode_pins_n[0]` sets `irq_pend_o` within 3 clocks. It stays set after the pin rises, until `irq_ack` is high on a clock edge.
- R7: `irq_ack` has no effect in level mode, and a rising pin transition never sets pending in edge mode.
- R8: `irq_req_o` equals `irq_pend_o` AND NOT `irq_mask`.
- R9: With `core_in_wait`=1, `wake_o` is high only when `irq_req_o` is high.
- R10: With `core_in_stop`=1, `wake_o` is high whenever `irq_pend_o` is high, even when masked.
- R11: While `core_rst_n` is low, `irq_pend_o`, `irq_req_o` and `wake_o` stay low whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_raw | input | 1 | Raw asynchronous reset, active low |
| mode_pins_n | input | MODE_W | Raw mode pins; bit 0 doubles as the active-low interrupt request |
| irq_mask | input | 1 | 1 blocks the request to the core |
| irq_edge_sel | input | 1 | 0 level-sensitive, 1 falling-edge latched |
| core_in_wait | input | 1 | Core is in the wait state |
| core_in_stop | input | 1 | Core is in the stop standby state |
| irq_ack | input | 1 | Clears a latched edge request |
| core_rst_n | output | 1 | Synchronized reset to the core, active low |
| phase_o | output | PH_W | Clock-phase counter value |
| mode_o | output | MODE_W | Latched operating mode |
| irq_pend_o | output | 1 | Interrupt pending, before the mask |
| irq_req_o | output | 1 | Masked interrupt request to the core |
| wake_o | output | 1 | Wake request for wait or stop |

## Verification
The bench sweeps all 8 mode pin patterns through a full reset cycle. Each run counts the release latency edge by edge, checks the captured mode and the phase sequence, and then moves the pins to show that the mode stays put. It also checks that a low interrupt pin during reset gives no request. The interrupt path is driven with falls, rises and acknowledges in both trigger modes, which separates an edge that is latched from a level that is followed. A sweep over trigger mode, mask, wait and stop, with a request both pending and absent, tells the masked wake from wait apart from the unmasked wake from stop.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_RUN     = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        IQ_OFF     = 2'd0,
        IQ_ARMED   = 2'd1,
        IQ_LATCHED = 2'd2
    } irq_state_e;

endpackage

// File: rtl/pinctl_rst_sync.sv
module pinctl_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_raw,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain;

    // asynchronous assertion, release ripples through STAGES flops
    always_ff @(posedge clk or negedge rst_n_raw) begin
        if (!rst_n_raw) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/pinctl_pin_sync.sv
module pinctl_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // pins must be sampled during reset, so the chain carries no reset
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pinctl_ctl.sv
module pinctl_ctl
    import pinctl_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int PHASES = 4,
    localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst_sync_n,
    input  logic [MODE_W-1:0] pins_s,
    output logic              run,
    output logic [MODE_W-1:0] mode_q,
    output logic [PH_W-1:0]   phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    ctl_state_e state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
            state <= ST_HOLD;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:    nxt = ST_CAPTURE;
            ST_CAPTURE: nxt = ST_RUN;
            ST_RUN:     nxt = ST_RUN;
            default:    nxt = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        run = 1'b0;
        unique case (state)
            ST_HOLD:    run = 1'b0;
            ST_CAPTURE: run = 1'b0;
            ST_RUN:     run = 1'b1;
            default:    run = 1'b0;
        endcase
    end

    // mode register: written only on the HOLD->CAPTURE edge
    always_ff @(posedge clk) begin
        if (rst_sync_n && state == ST_HOLD) begin
            mode_q <= pins_s;
        end
    end

    // phase generator, held at phase 0 outside run
    always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (state == ST_CAPTURE) |-> (mode_q == $past(pins_s)));

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (state == ST_RUN && $past(state) == ST_RUN) |-> $stable(mode_q));

    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        ($past(run) && run) |->
            (phase == (($past(phase) == PH_LAST) ? '0 : $past(phase) + 1'b1)));
endmodule

// File: rtl/pinctl_irq.sv
module pinctl_irq
    import pinctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pin_n_s,
    input  logic edge_sel,
    input  logic ack,
    output logic pending
);
    irq_state_e state, nxt;
    logic       prev_q;
    logic       fall;

    always_ff @(posedge clk) begin
        prev_q <= pin_n_s;
    end

    assign fall = prev_q & ~pin_n_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IQ_OFF;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            IQ_OFF: begin
                if (run && edge_sel) nxt = fall ? IQ_LATCHED : IQ_ARMED;
            end
            IQ_ARMED: begin
                if (!run || !edge_sel) nxt = IQ_OFF;
                else if (fall)         nxt = IQ_LATCHED;
            end
            IQ_LATCHED: begin
                if (!run || !edge_sel) nxt = IQ_OFF;
                else if (ack && !fall) nxt = IQ_ARMED;
            end
            default: nxt = IQ_OFF;
        endcase
    end

    // outputs
    always_comb begin
        pending = 1'b0;
        if (edge_sel) begin
            unique case (state)
                IQ_OFF:     pending = 1'b0;
                IQ_ARMED:   pending = 1'b0;
                IQ_LATCHED: pending = 1'b1;
                default:    pending = 1'b0;
            endcase
        end else begin
            pending = run & ~pin_n_s;
        end
    end

    p_edge_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_sel && pending && !ack) |=> (pending || !run || !edge_sel));

    p_level_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_sel && $past(!edge_sel) && run && $past(run) && $stable(pin_n_s))
            |-> (pending == $past(pending)));
endmodule

// File: rtl/pinctl_top.sv
module pinctl_top #(
    parameter int MODE_W      = 3,
    parameter int PHASES      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int PH_W       = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst_n_raw,
    input  logic [MODE_W-1:0] mode_pins_n,
    input  logic              irq_mask,
    input  logic              irq_edge_sel,
    input  logic              core_in_wait,
    input  logic              core_in_stop,
    input  logic              irq_ack,
    output logic              core_rst_n,
    output logic [PH_W-1:0]   phase_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_pend_o,
    output logic              irq_req_o,
    output logic              wake_o
);
    logic              rst_sync_n;
    logic [MODE_W-1:0] pins_s;
    logic              run;
    logic              pend;

    pinctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk        (clk),
        .rst_n_raw  (rst_n_raw),
        .rst_sync_n (rst_sync_n)
    );

    pinctl_pin_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_pins (
        .clk (clk),
        .d   (mode_pins_n),
        .q   (pins_s)
    );

    pinctl_ctl #(.MODE_W(MODE_W), .PHASES(PHASES)) u_ctl (
        .clk        (clk),
        .rst_sync_n (rst_sync_n),
        .pins_s     (pins_s),
        .run        (run),
        .mode_q     (mode_o),
        .phase      (phase_o)
    );

    pinctl_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .run      (run),
        .pin_n_s  (pins_s[0]),
        .edge_sel (irq_edge_sel),
        .ack      (irq_ack),
        .pending  (pend)
    );

    assign core_rst_n = run;
    assign irq_pend_o = pend;
    assign irq_req_o  = pend & ~irq_mask;
    // wait exits only on an enabled request; stop exits on any pending one
    assign wake_o     = run & ((core_in_wait & irq_req_o) | (core_in_stop & pend));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n_raw)
        !core_rst_n |-> (!irq_pend_o && !wake_o));

    p_phase_idle_r2: assert property (@(posedge clk) disable iff (!rst_n_raw)
        !core_rst_n |-> (phase_o == '0));

    p_stop_wake_r10: assert property (@(posedge clk) disable iff (!rst_n_raw)
        (core_in_stop && irq_pend_o) |-> wake_o);

    p_wait_mask_r9: assert property (@(posedge clk) disable iff (!rst_n_raw)
        (core_in_wait && !core_in_stop && wake_o) |-> !irq_mask);
endmodule

// File: tb/sim_pinctl_top.sv
module sim_pinctl_top;
    localparam int CLK_PERIOD = 10;
    localparam int MODE_W     = 3;
    localparam int PHASES     = 4;

    logic             clk = 1'b0;
    logic             rst_n_raw = 1'b0;
    logic [MODE_W-1:0] mode_pins_n = '1;
    logic             irq_mask = 1'b0;
    logic             irq_edge_sel = 1'b0;
    logic             core_in_wait = 1'b0;
    logic             core_in_stop = 1'b0;
    logic             irq_ack = 1'b0;
    logic             core_rst_n;
    logic [1:0]       phase_o;
    logic [MODE_W-1:0] mode_o;
    logic             irq_pend_o;
    logic             irq_req_o;
    logic             wake_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinctl_top #(.MODE_W(MODE_W), .PHASES(PHASES)) u0 (
        .clk, .rst_n_raw, .mode_pins_n, .irq_mask, .irq_edge_sel,
        .core_in_wait, .core_in_stop, .irq_ack, .core_rst_n, .phase_o,
        .mode_o, .irq_pend_o, .irq_req_o, .wake_o
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pin(input logic v);
        mode_pins_n[0] = v;
    endtask

    task automatic clear_req;
        set_pin(1'b1);
        tick(3);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // sweep every mode value through a reset cycle
        for (int m = 0; m < 8; m++) begin
            irq_edge_sel = 1'b0;
            rst_n_raw = 1'b0;
            #1;
            chk("R1 async assert", int'(core_rst_n), 0);
            mode_pins_n = 3'(m);
            tick(4);
            chk("R11 quiet in reset", int'(irq_pend_o | wake_o | irq_req_o), 0);
            chk("R2 phase in reset", int'(phase_o), 0);
            rst_n_raw = 1'b1;
            tick(3);
            chk("R1 low after 3 edges", int'(core_rst_n), 0);
            tick(1);
            chk("R1 high after 4 edges", int'(core_rst_n), 1);
            chk("R3 mode captured", int'(mode_o), m);
            for (int k = 0; k < 6; k++) begin
                chk("R2 phase sequence", int'(phase_o), k % PHASES);
                tick(1);
            end
            chk("R5 level after capture", int'(irq_pend_o), ((m & 1) == 0) ? 1 : 0);
            mode_pins_n = 3'(~m);
            tick(3);
            chk("R4 mode kept", int'(mode_o), m);
            mode_pins_n = '1;
            tick(3);
        end

        // level mode
        irq_edge_sel = 1'b0;
        set_pin(1'b0);
        tick(1);
        chk("R5 level latency 1", int'(irq_pend_o), 0);
        tick(1);
        chk("R5 level set", int'(irq_pend_o), 1);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk("R7 ack ignored in level", int'(irq_pend_o), 1);
        set_pin(1'b1);
        tick(2);
        chk("R5 level clear", int'(irq_pend_o), 0);

        // edge mode
        irq_edge_sel = 1'b1;
        tick(3);
        chk("R6 idle edge", int'(irq_pend_o), 0);
        set_pin(1'b0);
        tick(3);
        chk("R6 fall sets", int'(irq_pend_o), 1);
        set_pin(1'b1);
        tick(3);
        chk("R6 held after rise", int'(irq_pend_o), 1);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk("R6 ack clears", int'(irq_pend_o), 0);
        set_pin(1'b0);
        tick(3);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk("R6 ack with pin low", int'(irq_pend_o), 0);
        set_pin(1'b1);
        tick(3);
        chk("R7 rise does not set", int'(irq_pend_o), 0);

        // mask / wait / stop sweep
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 16; c++) begin
                int mk;
                int wt;
                int sp;
                int pd;
                int req;
                int wk;
                mk = c & 1;
                wt = (c >> 1) & 1;
                sp = (c >> 2) & 1;
                pd = (c >> 3) & 1;
                irq_edge_sel = e[0];
                irq_mask = mk[0];
                core_in_wait = wt[0];
                core_in_stop = sp[0];
                if (pd == 1) set_pin(1'b0);
                tick(3);
                req = pd & (mk ^ 1);
                wk = (wt & req) | (sp & pd);
                chk("R6/R5 pending", int'(irq_pend_o), pd);
                chk("R8 masked request", int'(irq_req_o), req);
                if (sp == 1) chk("R10 stop wake", int'(wake_o), wk);
                else chk("R9 wait wake", int'(wake_o), wk);
                clear_req();
            end
        end
        irq_mask = 1'b0;
        core_in_wait = 1'b0;
        core_in_stop = 1'b0;

        // reset while a request is pending
        irq_edge_sel = 1'b1;
        set_pin(1'b0);
        tick(3);
        rst_n_raw = 1'b0;
        tick(1);
        chk("R11 pending dropped in reset", int'(irq_pend_o), 0);
        chk("R2 phase cleared", int'(phase_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule